// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. A 16-bit scale word selects the rate: an 8-bit prescaler field in the upper byte divides by the field value plus one, and a 3-bit exponent code in the lowest bits divides further by a power of two. An all-ones exponent code bypasses both stages and selects the fastest rate. With a zero prescaler, codes 0 to 4 give divide ratios of 2 to 32. A prescaler of 0x1F multiplies those ratios by 32, giving 64 to 1024.

The controller raises a clock-enable input for the length of a frame. The scale word is captured on the cycle the enable rises, so a new value written during a frame has no effect until the next frame starts. While the enable is low the serial clock rests at a programmable idle level and both counters are held cleared. Next to the serial clock, the block drives single-cycle rise and fall strobes. The shift register uses these strobes in place of the clock edges themselves. Transmit and receive sides would each instantiate one copy, normally loaded with the same scale word.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is asserted, the serial clock and both strobes are low, whatever the enable and idle-level inputs are.
- R2: While the enable is low, the serial clock equals the idle-level input sampled on the previous clock edge, and neither strobe asserts.
- R3: With exponent code c (scale bits [2:0], 0 to 6) and prescaler value p (scale bits [15:8]), the serial clock toggles every (p+1)*2^c module cycles. The first toggle comes that many cycles after the first clock edge that samples the enable high.
- R4: Scale bits [7:3] have no effect on the rate.
- R5: Exponent code 7 selects bypass: the serial clock toggles on every module clock cycle while enabled, whatever the prescaler field holds.
- R6: The scale word is captured only on the edge where the enable is first sampled high. Changes to the scale input while the enable stays high do not alter the rate.
- R7: The rise strobe is high for exactly the cycles in which the serial clock has just gone from 0 to 1. The fall strobe is high for exactly the cycles in which it has just gone from 1 to 0. The two are never high together.
- R8: Dropping the enable returns the serial clock to the idle level one cycle later and clears both counters. The next frame again waits the full half period before its first toggle.
- R9: The first strobe of a frame is a rise when the idle level is 0 and a fall when it is 1.
- R10: Prescaler value 0x1F with codes 0 and 4 gives half periods of 32 and 512 module cycles, which are overall ratios of 64 and 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| sck_en | input | 1 | Serial clock enable, high for the length of a frame |
| cpol | input | 1 | Idle level of the serial clock |
| scale_i | input | 16 | Scale word: prescaler in [15:8], exponent code in [2:0] |
| sck | output | 1 | Serial clock |
| sck_rise | output | 1 | Single-cycle strobe, serial clock has just risen |
| sck_fall | output | 1 | Single-cycle strobe, serial clock has just fallen |

## Verification
A counter that fails to clear or a stale scale capture shows at the ports as a wrong distance from the enable edge to the first toggle. The bench measures this on every frame, so the error appears within the first half period. A wrong decode of the prescaler or exponent stretches or shortens every half period, and the per-cycle comparison catches it at the first mismatching edge. That edge is at most 512 cycles into a frame for the slowest setting tested. A mismatch between a strobe and the clock level, or a missing return to idle, shows on the very next cycle.

// File: rtl/spi_sclk_div_pkg.sv
package spi_sclk_div_pkg;
  // Field layout of the scale word
  localparam int SCALE_W  = 16;
  localparam int PRE_W    = 8;
  localparam int PRE_LSB  = 8;
  localparam int CODE_W   = 3;
  // Exponent stage counts up to 2^(max code) - 1 prescaler ticks
  localparam int EXP_W    = (1 << CODE_W) - 2;
  localparam logic [CODE_W-1:0] BYPASS_CODE = {CODE_W{1'b1}};
endpackage

// File: rtl/spi_sclk_div_decode.sv
module spi_sclk_div_decode
  import spi_sclk_div_pkg::*;
#(
  parameter int SW  = SCALE_W,
  parameter int PW  = PRE_W,
  parameter int PL  = PRE_LSB,
  parameter int CW  = CODE_W,
  parameter int EW  = EXP_W
) (
  input  logic [SW-1:0] scale,
  output logic          bypass,
  output logic [PW-1:0] pre_lim,
  output logic [EW-1:0] exp_lim
);
  logic [CW-1:0] code;

  assign code    = scale[CW-1:0];
  assign pre_lim = scale[PL+PW-1:PL];
  assign bypass  = (code == BYPASS_CODE);

  // Thermometer limit: code c gives 2^c - 1, i.e. 2^c ticks per half period
  for (genvar b = 0; b < EW; b++) begin : g_therm
    assign exp_lim[b] = (code > CW'(b));
  end
endmodule

// File: rtl/spi_sclk_div_prescale.sv
module spi_sclk_div_prescale #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick = !clr && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_sclk_div_expstage.sv
module spi_sclk_div_expstage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         half_done
);
  logic [W-1:0] cnt_q, cnt_d;

  assign half_done = !clr && step && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)            cnt_d = '0;
    else if (half_done) cnt_d = '0;
    else if (step)      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_sclk_div_outstage.sv
module spi_sclk_div_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic idle_lvl,
  input  logic flip,
  output logic sck,
  output logic rise,
  output logic fall
);
  logic sck_q, sck_d;
  logic rise_q, rise_d;
  logic fall_q, fall_d;

  always_comb begin
    sck_d  = sck_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (!active) begin
      sck_d = idle_lvl;
    end else if (flip) begin
      sck_d  = ~sck_q;
      rise_d = ~sck_q;
      fall_d = sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sck_q  <= sck_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign sck  = sck_q;
  assign rise = rise_q;
  assign fall = fall_q;
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_sclk_div_pkg::*;
#(
  parameter int SW = SCALE_W,
  parameter int PW = PRE_W,
  parameter int EW = EXP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_en,
  input  logic          cpol,
  input  logic [SW-1:0] scale_i,
  output logic          sck,
  output logic          sck_rise,
  output logic          sck_fall
);
  logic          run_q, run_d;
  logic [SW-1:0] scale_q, scale_d;
  logic          active;
  logic          bypass;
  logic [PW-1:0] pre_lim;
  logic [EW-1:0] exp_lim;
  logic          cnt_clr;
  logic          pre_tick;
  logic          half_done;
  logic          flip;

  // Frame tracking and scale capture on the enable's rising cycle
  always_comb begin
    run_d   = sck_en;
    scale_d = scale_q;
    if (sck_en && !run_q) scale_d = scale_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      scale_q <= '0;
    end else begin
      run_q   <= run_d;
      scale_q <= scale_d;
    end
  end

  assign active  = sck_en && run_q;
  assign cnt_clr = !active || bypass;

  spi_sclk_div_decode #(.SW(SW), .PW(PW), .EW(EW)) u_decode (
    .scale   (scale_q),
    .bypass  (bypass),
    .pre_lim (pre_lim),
    .exp_lim (exp_lim)
  );

  spi_sclk_div_prescale #(.W(PW)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .lim   (pre_lim),
    .tick  (pre_tick)
  );

  spi_sclk_div_expstage #(.W(EW)) u_exp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .step      (pre_tick),
    .lim       (exp_lim),
    .half_done (half_done)
  );

  assign flip = bypass ? active : half_done;

  spi_sclk_div_outstage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .idle_lvl (cpol),
    .flip     (flip),
    .sck      (sck),
    .rise     (sck_rise),
    .fall     (sck_fall)
  );
endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk #(
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck_en,
  input logic          cpol,
  input logic          sck,
  input logic          sck_rise,
  input logic          sck_fall,
  input logic          run_q,
  input logic [SW-1:0] scale_in,
  input logic [SW-1:0] scale_q
);
  // R7
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && sck_fall));

  // R7
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |-> (sck && !$past(sck)));

  // R7
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |-> (!sck && $past(sck)));

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_en |=> (sck == $past(cpol)) && !sck_rise && !sck_fall);

  // R6
  scale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_en && run_q) |=> $stable(scale_q));

  // R6
  scale_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_en && !run_q) |=> (scale_q == $past(scale_in)));

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!sck_rise && !sck_fall);
    end
  end
endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(.SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sck_en   (sck_en),
  .cpol     (cpol),
  .sck      (sck),
  .sck_rise (sck_rise),
  .sck_fall (sck_fall),
  .run_q    (run_q),
  .scale_in (scale_i),
  .scale_q  (scale_q)
);

// File: tb/tb_spi_sclk_divider.sv
module tb_spi_sclk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck_en = 1'b0;
  logic        cpol = 1'b0;
  logic [15:0] scale_i = 16'h0000;
  logic        sck, sck_rise, sck_fall;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_sclk_divider dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_en   (sck_en),
    .cpol     (cpol),
    .scale_i  (scale_i),
    .sck      (sck),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  // Half period in module cycles, from the scale word encoding
  function automatic int half_of(logic [15:0] s);
    if (s[2:0] == 3'd7) return 1;
    return (int'(s[15:8]) + 1) << s[2:0];
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sck,rise,fall} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    sck_en = 1'b1;
    cpol   = 1'b1;
    scale_i = 16'h0007;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outputs during reset", {sck, sck_rise, sck_fall}, 3'b000);
    sck_en = 1'b0;
    cpol   = 1'b0;
    rst_n  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 after release", {sck, sck_rise, sck_fall}, 3'b000);
  endtask

  task automatic t_idle();
    int bad = 0;
    cpol = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 idle level high", {sck, sck_rise, sck_fall}, 3'b100);
    cpol = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2 idle level low", {sck, sck_rise, sck_fall}, 3'b000);
    scale_i = 16'h0007;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk);
      @(negedge clk);
      if ({sck, sck_rise, sck_fall} !== 3'b000) bad++;
    end
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R2 disabled activity: actual %0d bad cycles expected 0", bad);
    end
  endtask

  // Runs one frame and compares every cycle against the expected waveform
  task automatic run_frame(string req, logic [15:0] scl, logic pol, int n,
                           int chg_at, logic [15:0] chg_val);
    int h = half_of(scl);
    int bad = 0;
    int first_i = -1;
    logic [2:0] f_act = 3'b000;
    logic [2:0] f_exp = 3'b000;
    @(negedge clk);
    scale_i = scl;
    cpol    = pol;
    sck_en  = 1'b1;
    @(posedge clk);
    for (int i = 0; i <= n; i++) begin
      int flips;
      logic e_sck, e_on;
      logic [2:0] ex;
      if (i > 0) @(posedge clk);
      @(negedge clk);
      flips = i / h;
      e_sck = pol ^ flips[0];
      e_on  = (i > 0) && (i % h == 0);
      ex    = {e_sck, e_on && e_sck, e_on && !e_sck};
      if ({sck, sck_rise, sck_fall} !== ex) begin
        if (bad == 0) begin
          first_i = i;
          f_act = {sck, sck_rise, sck_fall};
          f_exp = ex;
        end
        bad++;
      end
      if (i == chg_at) scale_i = chg_val;
    end
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: scale %h cycle %0d actual %b expected %b",
               req, scl, first_i, f_act, f_exp);
    end
    sck_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 return to idle", {sck, sck_rise, sck_fall}, {pol, 2'b00});
  endtask

  initial begin
    t_reset();
    t_idle();
    run_frame("R3 code0",            16'h0000, 1'b0, 12,   -1, 16'h0);
    run_frame("R3 code1",            16'h0001, 1'b0, 12,   -1, 16'h0);
    run_frame("R3 code4",            16'h0004, 1'b0, 70,   -1, 16'h0);
    run_frame("R3 code6",            16'h0006, 1'b0, 260,  -1, 16'h0);
    run_frame("R3 prescale3 code2",  16'h0302, 1'b0, 70,   -1, 16'h0);
    run_frame("R4 reserved bits",    16'h00F9, 1'b0, 12,   -1, 16'h0);
    run_frame("R5 bypass",           16'h0007, 1'b0, 10,   -1, 16'h0);
    run_frame("R5 bypass prescaler", 16'h5507, 1'b0, 10,   -1, 16'h0);
    run_frame("R10 div64",           16'h1F00, 1'b0, 130,  -1, 16'h0);
    run_frame("R10 div1024",         16'h1F04, 1'b0, 1100, -1, 16'h0);
    run_frame("R9 idle high",        16'h0001, 1'b1, 12,   -1, 16'h0);
    run_frame("R6 change ignored",   16'h0001, 1'b0, 20,    4, 16'h1F04);
    run_frame("R6 new value next",   16'h0003, 1'b0, 40,   -1, 16'h0);
    run_frame("R8 short frame",      16'h0003, 1'b1, 5,    -1, 16'h0);
    run_frame("R8 restart",          16'h0003, 1'b1, 40,   -1, 16'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule